// File: doc/BRIEF.md
# Two-Step Converter Digital Backend

This block is the digital half of an 8-bit two-step (half-flash) analog-to-digital converter. Two comparator banks supply 15-bit thermometer words. The coarse bank resolves the upper nibble while the input is being sampled. The fine bank resolves the residue that remains after the coarse estimate is subtracted, and gives the lower nibble. A single extra comparator on the coarse bank reports an input above full scale. Each thermometer word is reduced to a 4-bit value by counting its ones.

A conversion begins with a one-cycle `start` request. A sequencer then moves through three named states:
- `ST_IDLE` goes to `ST_SAMPLE` when `start` is accepted.
- `ST_SAMPLE` goes to `ST_FINE` after `SAMPLE_CYC` cycles. The coarse nibble and the over-range bit are captured on the last of those cycles.
- `ST_FINE` goes back to `ST_IDLE` after `FINE_CYC` cycles. The fine nibble is captured on the last of those cycles, and both nibbles move into the output register at the same edge.

The output is presented as plain binary for unipolar inputs or as offset binary for bipolar inputs. The mode is chosen per conversion. An over-range result is forced to all ones and is reported by a sticky flag.

Top module: `hfadc_backend`

## Requirements
- R1: Each nibble equals the number of ones in its 15-bit thermometer word (0 to 15), whether or not the ones are contiguous.
- R2: The coarse nibble and `over_in` are sampled on the final `ST_SAMPLE` cycle, which is the `SAMPLE_CYC`-th rising edge after the accepting edge. Later changes to `coarse_therm` or `over_in` do not affect the result.
- R3: The fine nibble is sampled on the final `ST_FINE` cycle. In unipolar mode (`bipolar`=0), `code` = {coarse nibble, fine nibble}, with the coarse nibble in bits 7:4.
- R4: When `bipolar` is 1 at the accepting edge, `code` equals the unipolar value with bit 7 inverted. The mode is held for the whole conversion.
- R5: If over-range was sampled, `code` is 8'hFF and `over_flag` is 1. `over_flag` stays set until the next `start` is accepted, and it reads 0 from the cycle after that acceptance.
- R6: `done` is high for exactly one cycle. It comes SAMPLE_CYC+FINE_CYC edges after the accepting edge, at the same edge where `code` updates.
- R7: `busy` is high from the cycle after acceptance until `done`. A `start` that arrives while `busy` is high is ignored.
- R8: After reset, `code` is 0 and `over_flag`, `done` and `busy` are all 0.
- R9: `code` holds its value between conversions and changes only at a `done` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request; accepted only when idle |
| bipolar | input | 1 | 1 = offset binary output, 0 = plain binary |
| coarse_therm | input | 15 | Coarse comparator thermometer word |
| fine_therm | input | 15 | Fine comparator thermometer word |
| over_in | input | 1 | Above-full-scale comparator |
| code | output | 8 | Conversion result |
| over_flag | output | 1 | Sticky over-range indicator |
| done | output | 1 | One-cycle strobe when code updates |
| busy | output | 1 | Conversion in progress |

## Verification
The assertions check the following on every cycle:
- `done` never lasts two cycles.
- `busy` falls only together with `done`.
- A request made while busy does not end the conversion early.
- `over_flag` always implies an all-ones code.
- `over_flag` clears right after acceptance.
- `code` moves only at a load.

Only the bench scenarios can show the following:
- Which edge samples each thermometer word and `over_in`.
- The exact arithmetic of the encoding for bubbled words.
- The bit-7 inversion in bipolar mode.
- The exact conversion latency.

// File: rtl/hfadc_pkg.sv
package hfadc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_FINE   = 2'd2
    } hf_state_t;
endpackage

// File: rtl/hfadc_therm_enc.sv
module hfadc_therm_enc #(
    parameter int NIB_W = 4,
    localparam int THERM_W = (1 << NIB_W) - 1
) (
    input  logic [THERM_W-1:0] therm,
    output logic [NIB_W-1:0]   nib
);
    // Ones count: tolerant of bubbles, result always within 0..THERM_W (R1)
    always_comb begin
        nib = '0;
        for (int i = 0; i < THERM_W; i++) begin
            nib = nib + NIB_W'(therm[i]);
        end
    end
endmodule

// File: rtl/hfadc_seq.sv
module hfadc_seq
    import hfadc_pkg::*;
#(
    parameter int SAMPLE_CYC = 4,
    parameter int FINE_CYC   = 3,
    localparam int MAXC  = (SAMPLE_CYC > FINE_CYC) ? SAMPLE_CYC : FINE_CYC,
    localparam int CNT_W = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic coarse_ld,
    output logic fine_ld,
    output logic busy,
    output logic done
);
    hf_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             sample_end, fine_end;

    assign sample_end = (cnt == CNT_W'(SAMPLE_CYC - 1));
    assign fine_end   = (cnt == CNT_W'(FINE_CYC - 1));

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_SAMPLE;
                    cnt_nx   = '0;
                end
            end
            ST_SAMPLE: begin
                if (sample_end) begin
                    state_nx = ST_FINE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_FINE: begin
                if (fine_end) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Outputs
    always_comb begin
        accept    = 1'b0;
        coarse_ld = 1'b0;
        fine_ld   = 1'b0;
        busy      = 1'b0;
        unique case (state)
            ST_IDLE:   accept = start;
            ST_SAMPLE: begin busy = 1'b1; coarse_ld = sample_end; end
            ST_FINE:   begin busy = 1'b1; fine_ld   = fine_end;   end
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= fine_ld;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !fine_ld) |=> busy); // R7
endmodule

// File: rtl/hfadc_datapath.sv
module hfadc_datapath #(
    parameter int NIB_W = 4,
    localparam int CODE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              coarse_ld,
    input  logic              fine_ld,
    input  logic              bipolar,
    input  logic              over_in,
    input  logic [NIB_W-1:0]  coarse_nib,
    input  logic [NIB_W-1:0]  fine_nib,
    output logic [CODE_W-1:0] code,
    output logic              over_flag
);
    logic [NIB_W-1:0]  coarse_q;
    logic              ovr_q;
    logic              mode_q;
    logic [CODE_W-1:0] raw, shaped;

    assign raw = {coarse_q, fine_nib};

    always_comb begin
        shaped = raw;
        if (mode_q) shaped[CODE_W-1] = ~raw[CODE_W-1];
        if (ovr_q)  shaped = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_q  <= '0;
            ovr_q     <= 1'b0;
            mode_q    <= 1'b0;
            code      <= '0;
            over_flag <= 1'b0;
        end else begin
            if (accept) begin
                mode_q    <= bipolar;
                over_flag <= 1'b0;
            end
            if (coarse_ld) begin
                coarse_q <= coarse_nib;
                ovr_q    <= over_in;
            end
            if (fine_ld) begin
                code      <= shaped;
                over_flag <= ovr_q;
            end
        end
    end

    AST_OVR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        over_flag |-> (code == '1)); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !over_flag); // R5
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fine_ld |=> $stable(code)); // R9
endmodule

// File: rtl/hfadc_backend.sv
module hfadc_backend #(
    parameter int NIB_W      = 4,
    parameter int SAMPLE_CYC = 4,
    parameter int FINE_CYC   = 3,
    localparam int THERM_W = (1 << NIB_W) - 1,
    localparam int CODE_W  = 2 * NIB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               bipolar,
    input  logic [THERM_W-1:0] coarse_therm,
    input  logic [THERM_W-1:0] fine_therm,
    input  logic               over_in,
    output logic [CODE_W-1:0]  code,
    output logic               over_flag,
    output logic               done,
    output logic               busy
);
    logic [NIB_W-1:0] coarse_nib, fine_nib;
    logic             accept, coarse_ld, fine_ld;

    hfadc_therm_enc #(.NIB_W(NIB_W)) u_enc_coarse (.therm(coarse_therm), .nib(coarse_nib));
    hfadc_therm_enc #(.NIB_W(NIB_W)) u_enc_fine   (.therm(fine_therm),   .nib(fine_nib));

    hfadc_seq #(.SAMPLE_CYC(SAMPLE_CYC), .FINE_CYC(FINE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .accept(accept), .coarse_ld(coarse_ld), .fine_ld(fine_ld),
        .busy(busy), .done(done)
    );

    hfadc_datapath #(.NIB_W(NIB_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .coarse_ld(coarse_ld), .fine_ld(fine_ld),
        .bipolar(bipolar), .over_in(over_in),
        .coarse_nib(coarse_nib), .fine_nib(fine_nib),
        .code(code), .over_flag(over_flag)
    );
endmodule

// File: tb/hfadc_backend_test.sv
module hfadc_backend_test;
    localparam int S = 4;
    localparam int F = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bipolar = 1'b0;
    logic [14:0] coarse_therm = '0;
    logic [14:0] fine_therm = '0;
    logic        over_in = 1'b0;
    logic [7:0]  code;
    logic        over_flag, done, busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hfadc_backend #(.NIB_W(4), .SAMPLE_CYC(S), .FINE_CYC(F)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .bipolar(bipolar),
        .coarse_therm(coarse_therm), .fine_therm(fine_therm), .over_in(over_in),
        .code(code), .over_flag(over_flag), .done(done), .busy(busy)
    );

    function automatic logic [3:0] ones(input logic [14:0] w);
        logic [3:0] n = '0;
        for (int i = 0; i < 15; i++) n = n + {3'b0, w[i]};
        return n;
    endfunction

    function automatic logic [14:0] therm_of(input int n);
        return 15'((32'd1 << n) - 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ct/ft/ov applied before start; ct2/ft2/ov2 applied once the coarse capture edge has passed
    task automatic run_conv(input string req, input logic mode,
                            input logic [14:0] ct, input logic [14:0] ft, input logic ov,
                            input logic [14:0] ct2, input logic [14:0] ft2, input logic ov2,
                            input bit restart_mid);
        logic [3:0] c, f;
        logic [7:0] exp;
        c = ones(ct);
        f = ones(ft2);
        exp = {c, f};
        if (mode) exp[7] = ~exp[7];
        if (ov) exp = 8'hFF;
        @(negedge clk);
        coarse_therm = ct; fine_therm = ft; over_in = ov; bipolar = mode; start = 1'b1;
        @(negedge clk);
        start = 1'b0; bipolar = ~mode;
        check({req, " R7 busy after accept"}, busy, 1);
        check({req, " R5 flag cleared on accept"}, over_flag, 0);
        for (int k = 1; k < S + F; k++) begin
            if (restart_mid && k == 2) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (k == S) begin
                coarse_therm = ct2; fine_therm = ft2; over_in = ov2;
            end
            check({req, " R6 no early done"}, done, 0);
        end
        @(negedge clk);
        check({req, " R6 done at latency"}, done, 1);
        check({req, " R3 R4 R5 code"}, code, exp);
        check({req, " R5 flag"}, over_flag, ov);
        @(negedge clk);
        check({req, " R6 done single cycle"}, done, 0);
        check({req, " R7 busy low, no restart"}, busy, 0);
        coarse_therm = 15'h2A5A; fine_therm = 15'h0F0F; over_in = 1'b1;
        repeat (3) @(negedge clk);
        check({req, " R9 code holds"}, code, exp);
        check({req, " R5 flag held"}, over_flag, ov);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8 code reset", code, 0);
        check("R8 flag reset", over_flag, 0);
        check("R8 done reset", done, 0);
        check("R8 busy reset", busy, 0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        // R1 R3 basic unipolar
        run_conv("R1 R3 uni 9/5", 1'b0, therm_of(9), therm_of(5), 1'b0,
                 therm_of(9), therm_of(5), 1'b0, 1'b0);
        // R1 extremes
        run_conv("R1 zero", 1'b0, therm_of(0), therm_of(0), 1'b0,
                 therm_of(0), therm_of(0), 1'b0, 1'b0);
        run_conv("R1 full", 1'b0, therm_of(15), therm_of(15), 1'b0,
                 therm_of(15), therm_of(15), 1'b0, 1'b0);
        // R1 bubbles counted as ones
        run_conv("R1 bubble", 1'b0, 15'b000_0000_0101_1011, 15'b100_0000_0000_0011, 1'b0,
                 15'b000_0000_0101_1011, 15'b100_0000_0000_0011, 1'b0, 1'b0);
        // R2 coarse and over_in sampled at sample end; R3 fine sampled at completion
        run_conv("R2 R3 late change", 1'b0, therm_of(3), therm_of(12), 1'b0,
                 therm_of(14), therm_of(7), 1'b1, 1'b0);
        // R4 bipolar
        run_conv("R4 bipolar 12/1", 1'b1, therm_of(12), therm_of(1), 1'b0,
                 therm_of(12), therm_of(1), 1'b0, 1'b0);
        run_conv("R4 bipolar 2/10", 1'b1, therm_of(2), therm_of(10), 1'b0,
                 therm_of(2), therm_of(10), 1'b0, 1'b0);
        // R5 over-range saturates, latched even if over_in drops
        run_conv("R5 over", 1'b0, therm_of(4), therm_of(4), 1'b1,
                 therm_of(4), therm_of(4), 1'b0, 1'b0);
        // R5 next conversion clears flag; R7 start during busy ignored
        run_conv("R7 restart ignored", 1'b1, therm_of(8), therm_of(0), 1'b0,
                 therm_of(8), therm_of(0), 1'b0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule